// File: doc/BRIEF.md
# Concurrent-Write Conflict Resolver

This block sits between a set of processing-element write ports and one shared memory during a single synchronous write phase. On each strobe, every port may offer a write: a valid bit, a target address and a data word. Ports that aim at the same address form a group. For each group, the block decides what reaches memory under a policy chosen at run time. The policies are: reject the collision, give the write to a fixed-priority port, accept only agreeing values, take the lowest port, draw a port at random, or merge all values with an associative operator.

The resolved writes come out on one output lane per port. A group's result always appears on the lane of its lowest-numbered member, and every other lane of that group stays idle. The results are registered, so the memory sees them one clock after the strobe. Error flags ride on the same lane as the write they replace.

Top module: `cw_resolver`

## Requirements
- R1: Outputs appear exactly one clock edge after a cycle with `phase_go` high. After any edge where `phase_go` was low, all of `mem_we`, `clash_err` and `mismatch_err` are zero.
- R2: A valid port whose address matches no other valid port is written to its own lane, with its address and data unchanged, in every mode.
- R3: Mode code 0 (exclusive): a group of two or more ports writes nothing, and `clash_err` rises on the group's lane.
- R4: Mode code 1 (priority): the member with the highest port index supplies the stored value.
- R5: Mode code 2 (common): if all members carry equal data, that value is written. Otherwise nothing is written and `mismatch_err` rises on the group's lane.
- R6: Mode code 3 (arbitrary): the member with the lowest port index supplies the stored value. Codes 6 and 7 behave the same way.
- R7: Mode code 4 (random): a 16-bit shift register starts at 16'hACE1 after reset. Each step computes next = {s[14:0], s[15]^s[13]^s[12]^s[10]}, and it steps once per strobe. The value before the step, modulo the member count, gives the rank (0 = lowest index) of the winning member.
- R8: Mode code 5 (combining), operator codes 0 (SUM) and 1 (PRODUCT): all member values are folded, and the result is kept modulo 2^DW. Operator code 7 behaves as SUM.
- R9: Combining, operator codes 2 (MAX) and 3 (MIN): the comparison is unsigned.
- R10: Combining, operator codes 4 (AND), 5 (OR) and 6 (XOR): the operator is applied bitwise across all members.
- R11: Each group's result appears only on the lane of its lowest-indexed member, carrying that group's address. All other lanes are idle, so no two asserted lanes share an address.
- R12: While `rst_n` is low at a clock edge, all outputs clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_go | input | 1 | Write-phase strobe |
| mode_sel | input | 3 | Resolution policy code |
| comb_op | input | 3 | Combining operator code |
| wr_vld | input | NPORT | Per-port write request |
| wr_addr | input | NPORT*AW | Per-port address, port i at bits [i*AW +: AW] |
| wr_data | input | NPORT*DW | Per-port data, port i at bits [i*DW +: DW] |
| mem_we | output | NPORT | Resolved write enable per lane |
| mem_addr | output | NPORT*AW | Resolved address per lane |
| mem_data | output | NPORT*DW | Resolved data per lane |
| clash_err | output | NPORT | Exclusive-mode collision flag per lane |
| mismatch_err | output | NPORT | Common-mode disagreement flag per lane |

## Verification
The bench builds the block with four ports, a 2-bit address and 8-bit data. With only four addresses, random traffic often puts three or four ports on the same address, so large groups, partial groups and singletons all occur together in one phase. With 8-bit data, products wrap after only two factors, and the MAX and MIN checks can use values whose top bit is set, which exposes any signed comparison. A long random run keeps the random mode in step with the register sequence across many strobes.

// File: rtl/cwr_pkg.sv
// Package: shared encodings for the concurrent-write resolver.
// Assumes 3-bit mode and operator fields on the top-level ports.
package cwr_pkg;
    typedef enum logic [2:0] {
        MODE_EXCL   = 3'd0,
        MODE_PRIO   = 3'd1,
        MODE_COMMON = 3'd2,
        MODE_ARB    = 3'd3,
        MODE_RAND   = 3'd4,
        MODE_COMB   = 3'd5
    } wmode_e;

    typedef enum logic [2:0] {
        OP_SUM  = 3'd0,
        OP_PROD = 3'd1,
        OP_MAX  = 3'd2,
        OP_MIN  = 3'd3,
        OP_AND  = 3'd4,
        OP_OR   = 3'd5,
        OP_XOR  = 3'd6
    } cop_e;

    localparam logic [15:0] LFSR_SEED_DEF = 16'hACE1;
endpackage

// File: rtl/cwr_group.sv
// Module: cwr_group
// Groups the valid ports by address. member[i*NPORT+j] is set when ports i
// and j are both valid and share an address. leader[i] marks the lowest-index
// valid port of each group. Purely combinational.
module cwr_group #(
    parameter int NPORT = 4,
    parameter int AW    = 4
) (
    input  logic [NPORT-1:0]       vld,
    input  logic [NPORT*AW-1:0]    addr,
    output logic [NPORT-1:0]       leader,
    output logic [NPORT*NPORT-1:0] member
);
    // Pairwise address match between valid ports.
    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            for (int j = 0; j < NPORT; j++) begin
                member[i*NPORT+j] = vld[i] && vld[j] &&
                                    (addr[i*AW +: AW] == addr[j*AW +: AW]);
            end
        end
    end

    // A port leads its group when no lower-index port matches it.
    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            leader[i] = vld[i];
            for (int j = 0; j < i; j++) begin
                if (member[i*NPORT+j]) leader[i] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/cwr_lfsr.sv
// Module: cwr_lfsr
// 16-bit Fibonacci shift register with taps 15,13,12,10. It steps once per
// write phase. Assumes a nonzero seed, so the state never reaches zero.
module cwr_lfsr #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step,
    output logic [15:0] state
);
    // Load the seed on reset and advance on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEED;
        else if (step) state <= {state[14:0], state[15] ^ state[13] ^ state[12] ^ state[10]};
    end

    // R7
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state != 16'd0);

    // R7
    lfsr_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> state != $past(state));
endmodule

// File: rtl/cwr_lane_reduce.sv
// Module: cwr_lane_reduce
// Resolves one group onto one output lane. The group is given as a member
// mask and is only meaningful when is_leader is set. Combinational; the
// random pick uses the shift-register value of the current phase.
module cwr_lane_reduce
    import cwr_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int DW    = 16
) (
    input  logic                is_leader,
    input  logic [NPORT-1:0]    mask,
    input  logic [NPORT*DW-1:0] data,
    input  logic [2:0]          mode,
    input  logic [2:0]          op,
    input  logic [15:0]         rnd,
    output logic                we,
    output logic [DW-1:0]       res,
    output logic                clash,
    output logic                mism
);
    int            cnt;
    int            pick;
    int            rank;
    logic          seen;
    logic          differ;
    logic [DW-1:0] lo_d, hi_d, rnd_d, acc, dj;

    // Walk members in index order: first/last value, random pick, fold, agreement.
    always_comb begin
        cnt    = $countones(mask);
        pick   = (cnt == 0) ? 0 : int'({16'd0, rnd}) % cnt;
        rank   = 0;
        seen   = 1'b0;
        differ = 1'b0;
        lo_d   = '0;
        hi_d   = '0;
        rnd_d  = '0;
        acc    = '0;
        dj     = '0;
        for (int j = 0; j < NPORT; j++) begin
            if (mask[j]) begin
                dj = data[j*DW +: DW];
                if (!seen) begin
                    lo_d = dj;
                    acc  = dj;
                end else begin
                    if (dj != lo_d) differ = 1'b1;
                    case (op)
                        OP_PROD: acc = acc * dj;
                        OP_MAX:  acc = (dj > acc) ? dj : acc;
                        OP_MIN:  acc = (dj < acc) ? dj : acc;
                        OP_AND:  acc = acc & dj;
                        OP_OR:   acc = acc | dj;
                        OP_XOR:  acc = acc ^ dj;
                        default: acc = acc + dj;
                    endcase
                end
                if (rank == pick) rnd_d = dj;
                hi_d = dj;
                rank = rank + 1;
                seen = 1'b1;
            end
        end
    end

    // Select the stored value and decide write or error for this lane.
    always_comb begin
        case (mode)
            MODE_PRIO: res = hi_d;
            MODE_RAND: res = rnd_d;
            MODE_COMB: res = acc;
            default:   res = lo_d;
        endcase
        clash = is_leader && (mode == MODE_EXCL) && (cnt > 1);
        mism  = is_leader && (mode == MODE_COMMON) && differ;
        we    = is_leader && !clash && !mism;
    end
endmodule

// File: rtl/cw_resolver.sv
// Module: cw_resolver (top)
// Resolves one write phase of NPORT ports into per-lane memory writes under
// a run-time policy. Each group's result lands on the lane of its lowest
// member. Results are registered one clock after phase_go. Synchronous
// active-low reset.
module cw_resolver
    import cwr_pkg::*;
#(
    parameter int          NPORT     = 4,
    parameter int          AW        = 4,
    parameter int          DW        = 16,
    parameter logic [15:0] RAND_SEED = LFSR_SEED_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                phase_go,
    input  logic [2:0]          mode_sel,
    input  logic [2:0]          comb_op,
    input  logic [NPORT-1:0]    wr_vld,
    input  logic [NPORT*AW-1:0] wr_addr,
    input  logic [NPORT*DW-1:0] wr_data,
    output logic [NPORT-1:0]    mem_we,
    output logic [NPORT*AW-1:0] mem_addr,
    output logic [NPORT*DW-1:0] mem_data,
    output logic [NPORT-1:0]    clash_err,
    output logic [NPORT-1:0]    mismatch_err
);
    localparam int CNTW = $clog2(NPORT + 1);

    logic [NPORT-1:0]       leader;
    logic [NPORT*NPORT-1:0] member;
    logic [15:0]            rnd;
    logic [NPORT-1:0]       lane_we, lane_clash, lane_mism;
    logic [NPORT*DW-1:0]    lane_data;

    cwr_group #(.NPORT(NPORT), .AW(AW)) u_group (
        .vld    (wr_vld),
        .addr   (wr_addr),
        .leader (leader),
        .member (member)
    );

    cwr_lfsr #(.SEED(RAND_SEED)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (phase_go),
        .state (rnd)
    );

    for (genvar g = 0; g < NPORT; g++) begin : g_lane
        cwr_lane_reduce #(.NPORT(NPORT), .DW(DW)) u_red (
            .is_leader (leader[g]),
            .mask      (member[g*NPORT +: NPORT]),
            .data      (wr_data),
            .mode      (mode_sel),
            .op        (comb_op),
            .rnd       (rnd),
            .we        (lane_we[g]),
            .res       (lane_data[g*DW +: DW]),
            .clash     (lane_clash[g]),
            .mism      (lane_mism[g])
        );
    end

    // Result stage: capture resolved lanes on a strobe, otherwise idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we       <= '0;
            mem_addr     <= '0;
            mem_data     <= '0;
            clash_err    <= '0;
            mismatch_err <= '0;
        end else if (phase_go) begin
            mem_we       <= lane_we;
            mem_addr     <= wr_addr;
            mem_data     <= lane_data;
            clash_err    <= lane_clash;
            mismatch_err <= lane_mism;
        end else begin
            mem_we       <= '0;
            mem_addr     <= '0;
            mem_data     <= '0;
            clash_err    <= '0;
            mismatch_err <= '0;
        end
    end

    // Checker support: how many leaders claim each port.
    logic [NPORT*CNTW-1:0] owners;
    always_comb begin
        for (int j = 0; j < NPORT; j++) begin
            owners[j*CNTW +: CNTW] = '0;
            for (int i = 0; i < NPORT; i++) begin
                if (leader[i] && member[i*NPORT+j])
                    owners[j*CNTW +: CNTW] = owners[j*CNTW +: CNTW] + 1'b1;
            end
        end
    end

    // R1
    we_needs_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|mem_we || |clash_err || |mismatch_err) |-> $past(phase_go));

    // R3
    clash_only_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |clash_err |-> $past(mode_sel) == MODE_EXCL);

    // R5
    mism_only_common_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |mismatch_err |-> $past(mode_sel) == MODE_COMMON);

    for (genvar a = 0; a < NPORT; a++) begin : g_chk
        // R11
        one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_vld[a] |-> owners[a*CNTW +: CNTW] == CNTW'(1));
        for (genvar b = a + 1; b < NPORT; b++) begin : g_pair
            // R11
            addr_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (mem_we[a] && mem_we[b]) |-> mem_addr[a*AW +: AW] != mem_addr[b*AW +: AW]);
        end
    end
endmodule

// File: tb/tb_cw_resolver.sv
module tb_cw_resolver;
    localparam int NP = 4;
    localparam int AW = 2;
    localparam int DW = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              phase_go = 1'b0;
    logic [2:0]        mode_sel = '0;
    logic [2:0]        comb_op = '0;
    logic [NP-1:0]     wr_vld = '0;
    logic [NP*AW-1:0]  wr_addr = '0;
    logic [NP*DW-1:0]  wr_data = '0;
    logic [NP-1:0]     mem_we, clash_err, mismatch_err;
    logic [NP*AW-1:0]  mem_addr;
    logic [NP*DW-1:0]  mem_data;

    int checks = 0;
    int failures = 0;

    logic [15:0]   m_lfsr;
    logic          e_we [NP];
    logic          e_ce [NP];
    logic          e_me [NP];
    logic [DW-1:0] e_d  [NP];
    logic [AW-1:0] e_a  [NP];

    cw_resolver #(.NPORT(NP), .AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .phase_go(phase_go), .mode_sel(mode_sel),
        .comb_op(comb_op), .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
        .clash_err(clash_err), .mismatch_err(mismatch_err)
    );

    always #5 clk = ~clk;

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] md, input logic [2:0] op);
        case (md)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd4: return "R7";
            3'd5: begin
                if (op == 3'd2 || op == 3'd3) return "R9";
                if (op >= 3'd4 && op <= 3'd6) return "R10";
                return "R8";
            end
            default: return "R6";
        endcase
    endfunction

    // Expected per-lane results from the requirements.
    task automatic model(input logic [2:0] md, input logic [2:0] op);
        for (int i = 0; i < NP; i++) begin
            logic lead;
            int n, k, r;
            logic [DW-1:0] first, last, pk, fold, v;
            logic dif;
            e_we[i] = 0; e_ce[i] = 0; e_me[i] = 0; e_d[i] = '0; e_a[i] = '0;
            lead = wr_vld[i];
            for (int j = 0; j < i; j++)
                if (wr_vld[j] && wr_addr[j*AW +: AW] == wr_addr[i*AW +: AW]) lead = 0;
            if (!lead) continue;
            n = 0;
            for (int j = i; j < NP; j++)
                if (wr_vld[j] && wr_addr[j*AW +: AW] == wr_addr[i*AW +: AW]) n++;
            k = int'({16'd0, m_lfsr}) % n;
            r = 0; dif = 0;
            first = wr_data[i*DW +: DW]; last = first; pk = first; fold = first;
            for (int j = i; j < NP; j++) begin
                if (!(wr_vld[j] && wr_addr[j*AW +: AW] == wr_addr[i*AW +: AW])) continue;
                v = wr_data[j*DW +: DW];
                if (r == k) pk = v;
                if (j != i) begin
                    if (v != first) dif = 1;
                    case (op)
                        3'd1: fold = DW'(fold * v);
                        3'd2: if (v > fold) fold = v;
                        3'd3: if (v < fold) fold = v;
                        3'd4: fold = fold & v;
                        3'd5: fold = fold | v;
                        3'd6: fold = fold ^ v;
                        default: fold = DW'(fold + v);
                    endcase
                end
                last = v;
                r++;
            end
            e_a[i] = wr_addr[i*AW +: AW];
            case (md)
                3'd0: begin e_ce[i] = (n > 1); e_we[i] = (n == 1); e_d[i] = first; end
                3'd1: begin e_we[i] = 1; e_d[i] = last; end
                3'd2: begin e_me[i] = dif; e_we[i] = !dif; e_d[i] = first; end
                3'd4: begin e_we[i] = 1; e_d[i] = pk; end
                3'd5: begin e_we[i] = 1; e_d[i] = fold; end
                default: begin e_we[i] = 1; e_d[i] = first; end
            endcase
        end
    endtask

    task automatic phase(input logic [2:0] md, input logic [2:0] op, input logic [NP-1:0] v,
                         input logic [NP*AW-1:0] a, input logic [NP*DW-1:0] d, input string note);
        string t;
        @(negedge clk);
        mode_sel = md; comb_op = op; wr_vld = v; wr_addr = a; wr_data = d;
        phase_go = 1'b1;
        model(md, op);
        t = (note.len() != 0) ? note : tag_of(md, op);
        @(negedge clk);
        phase_go = 1'b0;
        for (int i = 0; i < NP; i++) begin
            chk(mem_we[i] == e_we[i], t, $sformatf("lane%0d we", i), 32'(mem_we[i]), 32'(e_we[i]));
            chk(clash_err[i] == e_ce[i], t, $sformatf("lane%0d clash", i), 32'(clash_err[i]), 32'(e_ce[i]));
            chk(mismatch_err[i] == e_me[i], t, $sformatf("lane%0d mism", i), 32'(mismatch_err[i]), 32'(e_me[i]));
            if (e_we[i]) begin
                chk(mem_data[i*DW +: DW] == e_d[i], t, $sformatf("lane%0d data", i),
                    32'(mem_data[i*DW +: DW]), 32'(e_d[i]));
                chk(mem_addr[i*AW +: AW] == e_a[i], "R11", $sformatf("lane%0d addr", i),
                    32'(mem_addr[i*AW +: AW]), 32'(e_a[i]));
            end
        end
        m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
        @(negedge clk);
        // R1: no strobe on the previous edge, so everything is idle
        chk(mem_we == '0 && clash_err == '0 && mismatch_err == '0, "R1", "idle outputs",
            32'({mem_we, clash_err, mismatch_err}), 32'd0);
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        m_lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        // R12: reset clears outputs
        chk(mem_we == '0 && clash_err == '0 && mismatch_err == '0 && mem_data == '0,
            "R12", "reset outputs", 32'({mem_we, clash_err, mismatch_err}), 32'd0);
        rst_n = 1'b1;

        // R2: all ports on distinct addresses, every mode
        for (int md = 0; md < 6; md++)
            phase(3'(md), 3'd1, 4'b1111, {2'd3, 2'd2, 2'd1, 2'd0}, 32'h44332211, "R2");
        // All four ports on one address, each policy
        phase(3'd0, 3'd0, 4'b1111, 8'h00, 32'h04030201, "R3");
        phase(3'd1, 3'd0, 4'b1111, 8'h00, 32'h04030201, "R4");
        phase(3'd2, 3'd0, 4'b1111, 8'h55, 32'h77777777, "R5");
        phase(3'd2, 3'd0, 4'b1111, 8'h55, 32'h77787777, "R5");
        phase(3'd3, 3'd0, 4'b1111, 8'h00, 32'h04030201, "R6");
        phase(3'd7, 3'd0, 4'b0110, 8'h00, 32'h04030201, "R6");
        for (int q = 0; q < 6; q++)
            phase(3'd4, 3'd0, 4'b1111, 8'h00, 32'h40302010, "R7");
        phase(3'd5, 3'd0, 4'b1111, 8'h00, 32'hF0F00101, "R8");
        phase(3'd5, 3'd1, 4'b0011, 8'h00, 32'h00001010, "R8");
        phase(3'd5, 3'd1, 4'b1111, 8'h00, 32'h03050207, "R8");
        phase(3'd5, 3'd7, 4'b1111, 8'h00, 32'h01010101, "R8");
        phase(3'd5, 3'd2, 4'b1111, 8'h00, 32'h7F01FF80, "R9");
        phase(3'd5, 3'd3, 4'b1111, 8'h00, 32'h7F01FF80, "R9");
        phase(3'd5, 3'd3, 4'b1011, 8'h00, 32'h80FFFE81, "R9");
        phase(3'd5, 3'd4, 4'b1111, 8'h00, 32'hF3FE7FFF, "R10");
        phase(3'd5, 3'd5, 4'b1111, 8'h00, 32'h01020408, "R10");
        phase(3'd5, 3'd6, 4'b1111, 8'h00, 32'hFF0F3C01, "R10");
        // Two groups plus a gap on lane mapping
        phase(3'd3, 3'd0, 4'b1111, {2'd1, 2'd2, 2'd2, 2'd1}, 32'hAABBCCDD, "R11");

        // Constrained random phases
        for (int n = 0; n < 400; n++) begin
            logic [2:0] md, op;
            md = 3'($urandom_range(0, 7));
            op = 3'($urandom_range(0, 7));
            phase(md, op, 4'($urandom()), 8'($urandom()),
                  (($urandom_range(0, 3) == 0) ? {4{8'($urandom())}} : 32'($urandom())), "");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule